// File: doc/BRIEF.md
# Multi-Mode Transmit Serializer

This block takes transmit data from a host and sends it out as one serial bit stream at the line rate. The host delivers data in one of three forms: one bit per line slot, a 4-bit nibble, or an 8-bit byte. Parallel words go out most significant bit first, and consecutive words follow each other with no idle or repeated slots. The block also produces the host-side transmit clock. In parallel mode that clock is the line slot rate divided by the word width. In serial mode it is the reference clock passed straight through.

All logic runs on one fast system clock. The two possible line timing sources, the reference and the recovered receive timing, arrive as one-cycle slot enables. A select derived from the hub/host and remote-loopback pins chooses which enable moves the data. The parallel/serial and width selects are captured only while reset is held, so a width change needs a synchronous reset. When local loopback is asserted, the serialized stream is copied to a receive-side loopback output in the same bit order.

Top module: `tx_serializer`

## Requirements
- R1: With the serial mode latched (`cfg_par`=0 at reset), every selected slot puts the `ser_din` value sampled at that slot onto `line_out`. `cfg_byte` and `par_din` have no effect in this mode.
- R2: With 8-bit mode latched (`cfg_par`=1, `cfg_byte`=1), each word is `par_din[7:0]`, sampled on the slot that starts the word, and it is sent bit 7 first down to bit 0 over 8 selected slots.
- R3: With 4-bit mode latched (`cfg_par`=1, `cfg_byte`=0), each word is `par_din[3:0]`, sent bit 3 first over 4 selected slots. `par_din[7:4]` is ignored.
- R4: In a parallel mode of word length L, `host_clk_out` goes high on the slot that samples a word. It stays high for the first L/2 slots of the word and low for the remaining L/2.
- R5: In serial mode, `host_clk_out` equals `ref_clk_in`.
- R6: `use_rec_timing` is 1 when `cfg_host`=0 or `cfg_rloop`=1, and 0 otherwise, whatever the value of `cfg_lloop`. Slots come from `rec_bit_en` when it is 1 and from `ref_bit_en` when it is 0. The enable that is not selected has no effect.
- R7: `line_out` and the bit counter change only on a selected slot. Words follow each other with no gap and no repeated bit.
- R8: `cfg_par` and `cfg_byte` are sampled only while `rst_n` is low. Changing them outside reset does not change the word format.
- R9: `loop_out` equals `line_out` when `cfg_lloop`=1, and is 0 when `cfg_lloop`=0.
- R10: During and right after reset, `line_out` is 0 and the divided host clock is 0 until the first word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; latches mode selects |
| cfg_par | input | 1 | 1 = parallel host data, 0 = serial |
| cfg_byte | input | 1 | 1 = 8-bit words, 0 = 4-bit words (parallel only) |
| cfg_host | input | 1 | 1 = host timing, 0 = hub timing (recovered) |
| cfg_rloop | input | 1 | Remote loopback; forces recovered timing |
| cfg_lloop | input | 1 | Local loopback; enables `loop_out` |
| ref_bit_en | input | 1 | Line slot enable from the reference timing |
| rec_bit_en | input | 1 | Line slot enable from the recovered timing |
| ref_clk_in | input | 1 | Reference clock level, forwarded in serial mode |
| ser_din | input | 1 | Serial host data |
| par_din | input | 8 | Parallel host data |
| host_clk_out | output | 1 | Host transmit clock |
| line_out | output | 1 | Serialized line bit |
| loop_out | output | 1 | Local loopback copy of the line bit |
| use_rec_timing | output | 1 | 1 when recovered timing is selected |

## Verification
The bench builds the block with its default word width of 8 and nibble width of 4, so the byte, nibble and single-bit word lengths are all covered. Because word lengths 8, 4 and 1 all appear, the counter wrap, the half-period host clock and the pass-through clock are each exercised. Sparse and random slot enables on both timing sources show that the stream has no gaps when slots arrive irregularly. Mode pins changed outside reset show that the latched format is kept.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int unsigned WORD_W_DEF = 8;
  localparam int unsigned NIB_W_DEF  = 4;

  // bits per word for the latched mode
  function automatic int unsigned word_len(input logic par, input logic byte_w,
                                           input int unsigned ww, input int unsigned nw);
    if (!par) return 1;
    return byte_w ? ww : nw;
  endfunction

  // recovered timing when hub side or remote loopback
  function automatic logic pick_recovered(input logic host, input logic rloop);
    return (!host) || rloop;
  endfunction
endpackage

// File: rtl/tx_ser_tsel.sv
module tx_ser_tsel (
  input  logic cfg_host,
  input  logic cfg_rloop,
  input  logic ref_bit_en,
  input  logic rec_bit_en,
  output logic use_rec,
  output logic bit_en
);
  import tx_ser_pkg::*;
  always_comb begin
    use_rec = pick_recovered(cfg_host, cfg_rloop);
    bit_en  = use_rec ? rec_bit_en : ref_bit_en;
  end
endmodule

// File: rtl/tx_ser_shift.sv
module tx_ser_shift #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned LW = $clog2(WORD_W + 1),
  localparam int unsigned CW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              is_par,
  input  logic              is_byte,
  input  logic [LW-1:0]     len,
  input  logic              ser_din,
  input  logic [WORD_W-1:0] par_din,
  output logic [CW-1:0]     cnt,
  output logic              load,
  output logic              line_q
);
  logic [WORD_W-1:0] sreg;
  logic              last;

  always_comb begin
    load = bit_en && (cnt == '0);
    last = (int'(cnt) == int'(len) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sreg   <= '0;
      line_q <= 1'b0;
    end else if (bit_en) begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (!is_par) begin
        line_q <= ser_din;
      end else if (cnt == '0) begin
        line_q <= par_din[int'(len) - 1];
        sreg   <= par_din << (WORD_W - int'(len) + 1);
      end else begin
        line_q <= sreg[WORD_W-1];
        sreg   <= sreg << 1;
      end
    end
  end

  AST_HOLD_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_q) && $stable(cnt)); // R7
  AST_SERIAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !is_par) |=> line_q == $past(ser_din)); // R1
  AST_BYTE_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (load && is_par && is_byte) |=> line_q == $past(par_din[WORD_W-1])); // R2
endmodule

// File: rtl/tx_ser_hclk.sv
module tx_ser_hclk #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned LW = $clog2(WORD_W + 1),
  localparam int unsigned CW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          is_par,
  input  logic          load,
  input  logic [CW-1:0] cnt,
  input  logic [LW-1:0] len,
  input  logic          ref_clk_in,
  output logic          host_clk_out
);
  logic div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= 1'b0;
    else if (bit_en) div_q <= (int'(cnt) < int'(len) / 2);
  end

  always_comb host_clk_out = is_par ? div_q : ref_clk_in;

  AST_HCLK_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> $past(load)); // R4
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int unsigned WORD_W = tx_ser_pkg::WORD_W_DEF,
  parameter int unsigned NIB_W  = tx_ser_pkg::NIB_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_par,
  input  logic              cfg_byte,
  input  logic              cfg_host,
  input  logic              cfg_rloop,
  input  logic              cfg_lloop,
  input  logic              ref_bit_en,
  input  logic              rec_bit_en,
  input  logic              ref_clk_in,
  input  logic              ser_din,
  input  logic [WORD_W-1:0] par_din,
  output logic              host_clk_out,
  output logic              line_out,
  output logic              loop_out,
  output logic              use_rec_timing
);
  import tx_ser_pkg::*;
  localparam int unsigned LW = $clog2(WORD_W + 1);
  localparam int unsigned CW = $clog2(WORD_W);

  logic          mode_par, mode_byte, bit_en, load, line_q;
  logic [LW-1:0] len;
  logic [CW-1:0] cnt;

  // format selects are captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_par  <= cfg_par;
      mode_byte <= cfg_byte;
    end
  end

  always_comb len = LW'(word_len(mode_par, mode_byte, WORD_W, NIB_W));

  tx_ser_tsel u_tsel (
    .cfg_host(cfg_host), .cfg_rloop(cfg_rloop),
    .ref_bit_en(ref_bit_en), .rec_bit_en(rec_bit_en),
    .use_rec(use_rec_timing), .bit_en(bit_en)
  );

  tx_ser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_par(mode_par),
    .is_byte(mode_byte), .len(len), .ser_din(ser_din), .par_din(par_din),
    .cnt(cnt), .load(load), .line_q(line_q)
  );

  tx_ser_hclk #(.WORD_W(WORD_W)) u_hclk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_par(mode_par),
    .load(load), .cnt(cnt), .len(len), .ref_clk_in(ref_clk_in),
    .host_clk_out(host_clk_out)
  );

  always_comb begin
    line_out = line_q;
    loop_out = cfg_lloop & line_q;
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_par) && $stable(mode_byte)); // R8
  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_lloop |-> !loop_out); // R9
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !line_out); // R10
endmodule

// File: tb/tx_serializer_bench.sv
module tx_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_par = 1'b1, cfg_byte = 1'b1, cfg_host = 1'b1, cfg_rloop = 1'b0, cfg_lloop = 1'b0;
  logic ref_bit_en = 1'b0, rec_bit_en = 1'b0, ref_clk_in = 1'b0, ser_din = 1'b0;
  logic [7:0] par_din = '0;
  logic host_clk_out, line_out, loop_out, use_rec_timing;

  always #2.5 clk = ~clk;

  tx_serializer u_tx_serializer (
    .clk(clk), .rst_n(rst_n), .cfg_par(cfg_par), .cfg_byte(cfg_byte),
    .cfg_host(cfg_host), .cfg_rloop(cfg_rloop), .cfg_lloop(cfg_lloop),
    .ref_bit_en(ref_bit_en), .rec_bit_en(rec_bit_en), .ref_clk_in(ref_clk_in),
    .ser_din(ser_din), .par_din(par_din), .host_clk_out(host_clk_out),
    .line_out(line_out), .loop_out(loop_out), .use_rec_timing(use_rec_timing)
  );

  int n_chk = 0, n_bad = 0;
  int blen = 8, bcnt = 0;
  bit exp_div = 1'b0, prev_sel = 1'b0, done = 1'b0;
  bit exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string line_tag();
    if (blen == 1) return "R1";
    if (blen == 8) return "R2";
    return "R3";
  endfunction

  // one negedge: monitor results of the previous slot, then drive the next
  task automatic step(input bit ref_en_v, input bit rec_en_v);
    bit sel, exp_rec, e;
    @(negedge clk);
    if (prev_sel) begin
      if (exp_q.size() == 0) chk(1'b0, "R7", line_out, -1);
      else begin
        e = exp_q.pop_front();
        chk(line_out == e, line_tag(), line_out, e);
      end
    end
    if (blen == 1) chk(host_clk_out == ref_clk_in, "R5", host_clk_out, ref_clk_in);
    else           chk(host_clk_out == exp_div, "R4", host_clk_out, exp_div);
    chk(loop_out == (cfg_lloop & line_out), "R9", loop_out, cfg_lloop & line_out);
    exp_rec = !cfg_host || cfg_rloop;
    chk(use_rec_timing == exp_rec, "R6", use_rec_timing, exp_rec);
    // drive
    sel = exp_rec ? rec_en_v : ref_en_v;
    par_din = 8'($urandom);
    ser_din = $urandom_range(0, 1);
    if (sel) begin
      if (blen == 1) exp_q.push_back(ser_din);
      else if (bcnt == 0)
        for (int i = blen - 1; i >= 0; i--) exp_q.push_back(par_din[i]);
      exp_div = (bcnt < blen / 2);
      bcnt = (bcnt + 1) % blen;
    end
    ref_bit_en = ref_en_v;
    rec_bit_en = rec_en_v;
    ref_clk_in = ~ref_clk_in;
    prev_sel = sel;
  endtask

  task automatic do_reset(input bit par, input bit byt);
    @(negedge clk);
    cfg_par = par; cfg_byte = byt; rst_n = 1'b0;
    ref_bit_en = 1'b0; rec_bit_en = 1'b0;
    repeat (3) @(negedge clk);
    blen = !par ? 1 : (byt ? 8 : 4);
    bcnt = 0; exp_div = 1'b0; prev_sel = 1'b0;
    exp_q.delete();
    rst_n = 1'b1;
    // R10: reset state
    chk(line_out == 1'b0, "R10", line_out, 0);
    if (par) chk(host_clk_out == 1'b0, "R10", host_clk_out, 0);
  endtask

  task automatic run(input int n, input int dens, input bit noisy_other);
    bit a, b;
    for (int k = 0; k < n; k++) begin
      a = ($urandom_range(0, 99) < dens);
      b = noisy_other ? bit'($urandom_range(0, 1)) : 1'b0;
      if (!cfg_host || cfg_rloop) step(b, a); else step(a, b);
    end
  endtask

  initial begin
    // R2, R4, R7: byte mode, dense then sparse slots
    do_reset(1'b1, 1'b1);
    run(80, 100, 1'b0);
    run(120, 40, 1'b1);
    // R8: mode pins change without reset, byte format must persist
    cfg_par = 1'b0; cfg_byte = 1'b0;
    run(60, 70, 1'b0);
    // R3: nibble mode, upper bits random
    do_reset(1'b1, 1'b0);
    run(100, 100, 1'b0);
    // R9, R6: local loopback keeps reference timing
    cfg_lloop = 1'b1;
    run(100, 60, 1'b1);
    // R6: hub side selects recovered timing
    cfg_host = 1'b0;
    run(100, 60, 1'b1);
    cfg_host = 1'b1; cfg_rloop = 1'b1;
    run(100, 60, 1'b1);
    cfg_rloop = 1'b0; cfg_lloop = 1'b0;
    // R1, R5: serial mode, width select toggled
    do_reset(1'b0, 1'b1);
    for (int k = 0; k < 100; k++) begin
      cfg_byte = $urandom_range(0, 1);
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    cfg_lloop = 1'b1;
    run(60, 100, 1'b0);
    step(1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule